// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches recent logical-to-physical page translations for a single access stream. A lookup request carries a 32-bit logical address, a privilege flag and a direction flag. One cycle later the block returns exactly one of three answers: a hit with the physical address, a miss, or a protection fault. Each entry stores a physical page number and two protection bits. One bit reserves the page for supervisor accesses. The other forbids writes to it.

After a miss the block holds the failed request and ignores new ones until an external table walker delivers a descriptor on the fill port. The descriptor goes into the set selected by the held address, in an invalid way if there is one and otherwise in the way named by a per-set tree pseudo-LRU. The held access is then replayed and answered. A mode input selects 4 KiB or 8 KiB pages. The page size must only be changed after a flush. An enable input turns translation off, in which case addresses pass straight through. A flush input drops every entry in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset all response outputs are 0 and every entry is invalid, so the first enabled lookup of any address answers miss.
- R2: A request sampled on a clock edge produces, right after that edge, exactly one of rspHit, rspMiss or rspFault for one cycle; with no request all three stay 0 and rspPaddr is 0.
- R3: After a miss, further requests are ignored with no response until fillValid is sampled. The descriptor is installed on that edge and the held request is answered on the following edge.
- R4: With pageSize8k=0, the set index is address bits 15:12, the tag is bits 31:16, and a hit returns {ppn[19:0], addr[11:0]}.
- R5: With pageSize8k=1, the set index is address bits 16:13, the tag is bits 31:17, and a hit returns {ppn[19:1], addr[12:0]}; ppn bit 0 is ignored.
- R6: A hit on an entry filled with fillSuperOnly=1 by a request with reqSuper=0 answers rspFault with rspPaddr 0; with reqSuper=1 it answers hit.
- R7: A hit on an entry filled with fillWriteProt=1 by a request with reqWrite=1 answers rspFault with rspPaddr 0; a read answers hit.
- R8: With xlatEnable=0 every request answers rspHit with rspPaddr equal to reqAddr, never misses, and leaves the stored entries unchanged.
- R9: A flush pulse invalidates every entry on its clock edge; the next lookup of a previously resident page misses.
- R10: Four pages with the same set index and different tags are all resident together; fills go to the lowest-numbered invalid way first.
- R11: When all four ways are valid, a fill replaces the way chosen by a 3-bit tree pseudo-LRU that every hit and fill steers away from the touched way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Logical address |
| reqSuper | input | 1 | 1 = supervisor access, 0 = user |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| xlatEnable | input | 1 | 0 = pass addresses through untranslated |
| pageSize8k | input | 1 | 0 = 4 KiB pages, 1 = 8 KiB pages |
| flush | input | 1 | Invalidate all entries |
| fillValid | input | 1 | Descriptor present on the fill port |
| fillPpn | input | 20 | Physical page number in 4 KiB units |
| fillSuperOnly | input | 1 | Descriptor: supervisor-only page |
| fillWriteProt | input | 1 | Descriptor: write-protected page |
| rspHit | output | 1 | Translation succeeded |
| rspMiss | output | 1 | No matching entry, waiting for fill |
| rspFault | output | 1 | Matching entry refuses this access |
| rspPaddr | output | 32 | Physical address on a hit, else 0 |

## Verification
A table of accesses in 4 KiB mode mixes first touches, repeat touches of the same page at other offsets, and user or write accesses to protected pages. This separates a correct tag match from a false one and a permission fault from a plain hit. Directed sequences then fill five pages into one set. The victim they reveal tells the tree replacement apart from FIFO or random order. Further sequences send a request while a fill is outstanding, which shows whether a waiting block drops it. They also repeat accesses in 8 KiB mode at two offsets of one page, which shows where the index and offset split, and they flush and disable the block around resident pages.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_REPLAY = 2'd2
  } xlatState_t;

  typedef struct packed {
    logic lookup;   // compare tags and register a response this cycle
    logic useHeld;  // compare the held request instead of the live one
    logic capture;  // latch the live request
    logic fillWe;   // install the fill descriptor
  } xlatCtrl_t;

endpackage

// File: rtl/xlat_control.sv
module xlat_control
  import xlat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      fillValid,
  input  logic      lkMiss,
  output xlatCtrl_t ctrl
);

  xlatState_t stateQ, stateD;

  always_comb begin
    ctrl = '0;
    case (stateQ)
      ST_IDLE: begin
        ctrl.lookup  = reqValid;
        ctrl.capture = reqValid;
      end
      ST_WAIT:   ctrl.fillWe = fillValid;
      ST_REPLAY: begin
        ctrl.lookup  = 1'b1;
        ctrl.useHeld = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:   if (reqValid && lkMiss) stateD = ST_WAIT;
      ST_WAIT:   if (fillValid) stateD = ST_REPLAY;
      ST_REPLAY: stateD = lkMiss ? ST_WAIT : ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R3: a fill is only taken when nothing is being compared in the same cycle
  assert_fill_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fillWe |-> !ctrl.lookup);

endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SETS     = 16,
  parameter int WAYS     = 4,
  parameter int SMALL_SH = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  xlatCtrl_t                  ctrl,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic                       reqSuper,
  input  logic                       reqWrite,
  input  logic                       xlatEnable,
  input  logic                       pageSize8k,
  input  logic                       flush,
  input  logic [ADDR_W-SMALL_SH-1:0] fillPpn,
  input  logic                       fillSuperOnly,
  input  logic                       fillWriteProt,
  output logic                       lkMiss,
  output logic                       rspHit,
  output logic                       rspMiss,
  output logic                       rspFault,
  output logic [ADDR_W-1:0]          rspPaddr
);

  localparam int IDX_W  = $clog2(SETS);
  localparam int PPN_W  = ADDR_W - SMALL_SH;
  localparam int TAG_W  = PPN_W - IDX_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int PLRU_W = WAYS - 1;

  // tree pseudo-LRU for four ways: bit0 picks the pair, bit1/bit2 the way in it
  function automatic logic [PLRU_W-1:0] plruTouch(input logic [PLRU_W-1:0] p,
                                                  input logic [WAY_W-1:0] w);
    logic [PLRU_W-1:0] n;
    n = p;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  function automatic logic [WAY_W-1:0] plruVictim(input logic [PLRU_W-1:0] p);
    return p[0] ? {1'b1, p[2]} : {1'b0, p[1]};
  endfunction

  // storage
  logic [WAYS-1:0]   validQ [SETS];
  logic [WAYS-1:0]   soQ    [SETS];
  logic [WAYS-1:0]   wpQ    [SETS];
  logic [PLRU_W-1:0] plruQ  [SETS];
  logic [TAG_W-1:0]  tagQ   [SETS][WAYS];
  logic [PPN_W-1:0]  ppnQ   [SETS][WAYS];

  logic [ADDR_W-1:0] heldAddr;
  logic              heldSuper, heldWrite;

  // lookup side
  logic [ADDR_W-1:0] curAddr;
  logic              curSuper, curWrite;
  logic [IDX_W-1:0]  curIdx;
  logic [TAG_W-1:0]  curTag;
  logic [WAYS-1:0]   wayHit;
  logic              anyHit;
  logic [WAY_W-1:0]  hitWay;
  logic [PPN_W-1:0]  selPpn;
  logic              permFault;
  logic [ADDR_W-1:0] xlatPa;

  always_comb begin
    curAddr  = ctrl.useHeld ? heldAddr  : reqAddr;
    curSuper = ctrl.useHeld ? heldSuper : reqSuper;
    curWrite = ctrl.useHeld ? heldWrite : reqWrite;
    curIdx   = pageSize8k ? curAddr[SMALL_SH+1 +: IDX_W] : curAddr[SMALL_SH +: IDX_W];
    curTag   = pageSize8k ? {1'b0, curAddr[ADDR_W-1 -: TAG_W-1]}
                          : curAddr[ADDR_W-1 -: TAG_W];
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validQ[curIdx][w] && (tagQ[curIdx][w] == curTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayHit[w]) hitWay = WAY_W'(w);
    anyHit    = |wayHit;
    selPpn    = ppnQ[curIdx][hitWay];
    permFault = (soQ[curIdx][hitWay] && !curSuper) || (wpQ[curIdx][hitWay] && curWrite);
    xlatPa    = pageSize8k ? {selPpn[PPN_W-1:1], curAddr[SMALL_SH:0]}
                           : {selPpn, curAddr[SMALL_SH-1:0]};
    lkMiss    = ctrl.lookup && xlatEnable && !anyHit;
  end

  // fill side: always targets the held request
  logic [IDX_W-1:0] fillIdx;
  logic [TAG_W-1:0] fillTag;
  logic [WAY_W-1:0] victimWay;
  logic [WAYS-1:0]  fillSetValid;

  always_comb begin
    fillIdx = pageSize8k ? heldAddr[SMALL_SH+1 +: IDX_W] : heldAddr[SMALL_SH +: IDX_W];
    fillTag = pageSize8k ? {1'b0, heldAddr[ADDR_W-1 -: TAG_W-1]}
                         : heldAddr[ADDR_W-1 -: TAG_W];
    fillSetValid = validQ[fillIdx];
    victimWay    = plruVictim(plruQ[fillIdx]);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!fillSetValid[w]) victimWay = WAY_W'(w);
  end

  // valid bits and replacement state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || flush) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        plruQ[s]  <= '0;
      end
    end else if (ctrl.fillWe) begin
      validQ[fillIdx][victimWay] <= 1'b1;
      plruQ[fillIdx]             <= plruTouch(plruQ[fillIdx], victimWay);
    end else if (ctrl.lookup && xlatEnable && anyHit) begin
      plruQ[curIdx] <= plruTouch(plruQ[curIdx], hitWay);
    end
  end

  // entry payload
  always_ff @(posedge clk) begin
    if (ctrl.fillWe) begin
      tagQ[fillIdx][victimWay] <= fillTag;
      ppnQ[fillIdx][victimWay] <= fillPpn;
      soQ[fillIdx][victimWay]  <= fillSuperOnly;
      wpQ[fillIdx][victimWay]  <= fillWriteProt;
    end
  end

  // held request and registered response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr  <= '0;
      heldSuper <= 1'b0;
      heldWrite <= 1'b0;
      rspHit    <= 1'b0;
      rspMiss   <= 1'b0;
      rspFault  <= 1'b0;
      rspPaddr  <= '0;
    end else begin
      if (ctrl.capture) begin
        heldAddr  <= reqAddr;
        heldSuper <= reqSuper;
        heldWrite <= reqWrite;
      end
      rspHit   <= ctrl.lookup && (!xlatEnable || (anyHit && !permFault));
      rspFault <= ctrl.lookup && xlatEnable && anyHit && permFault;
      rspMiss  <= lkMiss;
      if (!ctrl.lookup)        rspPaddr <= '0;
      else if (!xlatEnable)    rspPaddr <= curAddr;
      else if (anyHit && !permFault) rspPaddr <= xlatPa;
      else                     rspPaddr <= '0;
    end
  end

  logic anyValid;
  always_comb begin
    anyValid = 1'b0;
    for (int s = 0; s < SETS; s++) anyValid = anyValid | (|validQ[s]);
  end

  // R9: nothing survives a flush edge
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !anyValid);

  // R6 R7: a refused access never exposes a physical address
  assert_fault_hides_pa_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspPaddr == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SETS     = 16,
  parameter int WAYS     = 4,
  parameter int SMALL_SH = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic                       reqSuper,
  input  logic                       reqWrite,
  input  logic                       xlatEnable,
  input  logic                       pageSize8k,
  input  logic                       flush,
  input  logic                       fillValid,
  input  logic [ADDR_W-SMALL_SH-1:0] fillPpn,
  input  logic                       fillSuperOnly,
  input  logic                       fillWriteProt,
  output logic                       rspHit,
  output logic                       rspMiss,
  output logic                       rspFault,
  output logic [ADDR_W-1:0]          rspPaddr
);

  xlatCtrl_t ctrl;
  logic      lkMiss;

  xlat_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .fillValid (fillValid),
    .lkMiss    (lkMiss),
    .ctrl      (ctrl)
  );

  xlat_datapath #(
    .ADDR_W   (ADDR_W),
    .SETS     (SETS),
    .WAYS     (WAYS),
    .SMALL_SH (SMALL_SH)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .reqAddr       (reqAddr),
    .reqSuper      (reqSuper),
    .reqWrite      (reqWrite),
    .xlatEnable    (xlatEnable),
    .pageSize8k    (pageSize8k),
    .flush         (flush),
    .fillPpn       (fillPpn),
    .fillSuperOnly (fillSuperOnly),
    .fillWriteProt (fillWriteProt),
    .lkMiss        (lkMiss),
    .rspHit        (rspHit),
    .rspMiss       (rspMiss),
    .rspFault      (rspFault),
    .rspPaddr      (rspPaddr)
  );

  // R2: at most one answer at a time
  assert_onehot_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspHit, rspMiss, rspFault}));

  // R2: an answer always follows a compare in the previous cycle
  assert_resp_after_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit || rspMiss || rspFault) |-> ($past(ctrl.lookup) && $past(rstN)));

  // R3: while a miss is being reported the block is waiting, not comparing
  assert_miss_stalls_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> !ctrl.lookup);

  // R8: disabled translation reflects the request address
  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrl.lookup && !ctrl.useHeld && !xlatEnable))
      |-> (rspHit && rspPaddr == $past(reqAddr)));

endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqSuper = 1'b0;
  logic        reqWrite = 1'b0;
  logic        xlatEnable = 1'b1;
  logic        pageSize8k = 1'b0;
  logic        flush = 1'b0;
  logic        fillValid = 1'b0;
  logic [19:0] fillPpn = '0;
  logic        fillSuperOnly = 1'b0;
  logic        fillWriteProt = 1'b0;
  logic        rspHit, rspMiss, rspFault;
  logic [31:0] rspPaddr;

  int total = 0;
  int bad = 0;
  int gotKind;
  logic [31:0] gotPa;

  // response kinds: 0 none, 1 hit, 2 miss, 3 fault, 7 several
  localparam int K_NONE = 0, K_HIT = 1, K_MISS = 2, K_FAULT = 3;

  always #2 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSuper(reqSuper), .reqWrite(reqWrite), .xlatEnable(xlatEnable),
    .pageSize8k(pageSize8k), .flush(flush), .fillValid(fillValid),
    .fillPpn(fillPpn), .fillSuperOnly(fillSuperOnly), .fillWriteProt(fillWriteProt),
    .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault), .rspPaddr(rspPaddr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        sup;
    logic        wr;
    logic [19:0] ppn;
    logic        so;
    logic        wp;
    logic        expMiss;
    logic [1:0]  expKind;
    logic [31:0] expPa;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h0001_2345, 1'b1, 1'b0, 20'hABCDE, 1'b0, 1'b0, 1'b1, 2'd1, 32'hABCD_E345},
    '{32'h0001_2FFF, 1'b0, 1'b1, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd1, 32'hABCD_EFFF},
    '{32'h4000_3010, 1'b1, 1'b0, 20'h11111, 1'b1, 1'b0, 1'b1, 2'd1, 32'h1111_1010},
    '{32'h4000_3020, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0000_0000},
    '{32'h8000_5008, 1'b0, 1'b0, 20'h22222, 1'b0, 1'b1, 1'b1, 2'd1, 32'h2222_2008},
    '{32'h8000_5ABC, 1'b0, 1'b1, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0000_0000},
    '{32'h8000_5ABC, 1'b1, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd1, 32'h2222_2ABC}
  };

  function automatic int kindOf();
    case ({rspHit, rspMiss, rspFault})
      3'b000:  return K_NONE;
      3'b100:  return K_HIT;
      3'b010:  return K_MISS;
      3'b001:  return K_FAULT;
      default: return 7;
    endcase
  endfunction

  task automatic grab();
    gotKind = kindOf();
    gotPa   = rspPaddr;
  endtask

  task automatic check(input string tag, input int expKind, input logic [31:0] expPa);
    total++;
    if (gotKind != expKind || gotPa !== expPa) begin
      bad++;
      $display("FAIL %s: kind=%0d pa=%h, expected kind=%0d pa=%h",
               tag, gotKind, gotPa, expKind, expPa);
    end
  endtask

  task automatic doLookup(input logic [31:0] a, input logic s, input logic w);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSuper = s; reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
    grab();
  endtask

  task automatic doFill(input logic [19:0] ppn, input logic so, input logic wp);
    @(negedge clk);
    fillValid = 1'b1; fillPpn = ppn; fillSuperOnly = so; fillWriteProt = wp;
    @(negedge clk);
    fillValid = 1'b0;
    @(negedge clk);
    grab();
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // lookup, and if it misses, serve the walk and check the replayed answer
  task automatic access(input string tag, input logic [31:0] a, input logic s,
                        input logic w, input logic [19:0] ppn, input logic so,
                        input logic wp, input logic expMiss, input int expKind,
                        input logic [31:0] expPa);
    doLookup(a, s, w);
    if (expMiss) check(tag, K_MISS, 32'h0);
    else         check(tag, expKind, expPa);
    if (gotKind == K_MISS) begin
      doFill(ppn, so, wp);
      check(tag, expKind, expPa);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: kind=%0d pa=%h, expected completion", gotKind, gotPa);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    grab();
    check("R1 reset outputs", K_NONE, 32'h0);
    @(negedge clk);
    grab();
    check("R2 idle no response", K_NONE, 32'h0);

    // R4 R6 R7 table walk, 4 KiB pages; first vector misses after reset (R1)
    for (int i = 0; i < 7; i++) begin
      access($sformatf("R4/R6/R7 vector %0d", i), VECS[i].addr, VECS[i].sup,
             VECS[i].wr, VECS[i].ppn, VECS[i].so, VECS[i].wp, VECS[i].expMiss,
             int'(VECS[i].expKind), VECS[i].expPa);
    end

    // R9 flush forgets resident page
    doFlush();
    access("R9 after flush", 32'h0001_2345, 1'b1, 1'b0, 20'hABCDE, 1'b0, 1'b0,
           1'b1, K_HIT, 32'hABCD_E345);

    // R10 R11 five tags on set 7
    doFlush();
    access("R10 fill A", 32'h0001_7000, 1'b1, 1'b0, 20'h000A0, 1'b0, 1'b0, 1'b1, K_HIT, 32'h000A_0000);
    access("R10 fill B", 32'h0002_7000, 1'b1, 1'b0, 20'h000B0, 1'b0, 1'b0, 1'b1, K_HIT, 32'h000B_0000);
    access("R10 fill C", 32'h0003_7000, 1'b1, 1'b0, 20'h000C0, 1'b0, 1'b0, 1'b1, K_HIT, 32'h000C_0000);
    access("R10 fill D", 32'h0004_7000, 1'b1, 1'b0, 20'h000D0, 1'b0, 1'b0, 1'b1, K_HIT, 32'h000D_0000);
    access("R10 A resident", 32'h0001_7004, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, K_HIT, 32'h000A_0004);
    access("R10 B resident", 32'h0002_7008, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, K_HIT, 32'h000B_0008);
    access("R10 C resident", 32'h0003_700C, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, K_HIT, 32'h000C_000C);
    access("R10 D resident", 32'h0004_7010, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, K_HIT, 32'h000D_0010);
    access("R11 touch A", 32'h0001_7000, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, K_HIT, 32'h000A_0000);
    access("R11 fill E", 32'h0005_7000, 1'b1, 1'b0, 20'h000E0, 1'b0, 1'b0, 1'b1, K_HIT, 32'h000E_0000);
    access("R11 A kept", 32'h0001_7000, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, K_HIT, 32'h000A_0000);
    access("R11 B kept", 32'h0002_7000, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, K_HIT, 32'h000B_0000);
    access("R11 D kept", 32'h0004_7000, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, K_HIT, 32'h000D_0000);
    access("R11 E kept", 32'h0005_7000, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, K_HIT, 32'h000E_0000);
    access("R11 C evicted", 32'h0003_7000, 1'b1, 1'b0, 20'h000C0, 1'b0, 1'b0, 1'b1, K_HIT, 32'h000C_0000);

    // R8 pass-through, then resident entry untouched
    xlatEnable = 1'b0;
    doLookup(32'hDEAD_BEEF, 1'b0, 1'b1);
    check("R8 pass-through", K_HIT, 32'hDEAD_BEEF);
    doLookup(32'h0002_7000, 1'b0, 1'b0);
    check("R8 pass-through resident addr", K_HIT, 32'h0002_7000);
    xlatEnable = 1'b1;
    doLookup(32'h0002_7000, 1'b1, 1'b0);
    check("R8 entry unchanged", K_HIT, 32'h000B_0000);

    // R3 requests ignored while waiting; replay answers the held one
    doLookup(32'h0009_9000, 1'b1, 1'b0);
    check("R3 miss", K_MISS, 32'h0);
    doLookup(32'h000A_A000, 1'b1, 1'b0);
    check("R3 ignored while waiting", K_NONE, 32'h0);
    doFill(20'h12345, 1'b0, 1'b0);
    check("R3 replay of held request", K_HIT, 32'h1234_5000);
    access("R3 held page installed", 32'h0009_9123, 1'b0, 1'b1, 20'h0, 1'b0, 1'b0,
           1'b0, K_HIT, 32'h1234_5123);
    access("R3 ignored page not installed", 32'h000A_A000, 1'b1, 1'b0, 20'h00777,
           1'b0, 1'b0, 1'b1, K_HIT, 32'h0077_7000);

    // R5 8 KiB pages
    doFlush();
    pageSize8k = 1'b1;
    access("R5 8k fill", 32'h1234_7ABC, 1'b1, 1'b0, 20'h55555, 1'b0, 1'b0,
           1'b1, K_HIT, 32'h5555_5ABC);
    access("R5 8k lower half", 32'h1234_6000, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0,
           1'b0, K_HIT, 32'h5555_4000);

    @(negedge clk);
    grab();
    check("R2 quiet after tests", K_NONE, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule